// File: doc/BRIEF.md
# Memory Access Checker and Router

This block sits between a processor's load/store stage and two targets: main memory and a memory-mapped device space. It takes one request at a time. Each request carries an address, a size of 1, 2, 4 or 8 bytes, a read/write bit, a bit that marks a read as an instruction fetch, and three ordering flags: acquire, release, and a reservation/conditional flag. The block checks the request and gives it one of three outcomes: an exception cause, an unsupported-combination error, or a transaction on exactly one target port.

Alignment is enforced only for ordered or atomic accesses. Plain misaligned accesses pass through to the targets. Reads and writes use separate device-space windows. Instruction fetches never reach the device port. Every routed store carries a three-bit ordering tag that the target uses to honour release and conditional semantics. Requests and responses use valid/ready handshakes. Exactly one response is returned per accepted request, in order.

Top module: `mem_access_router`

## Requirements
- R1: `req_ready` is high only when no transaction and no response are pending, so at most one request is in flight. A response stays valid, with `rsp_data`, `rsp_exc` and `rsp_cause` unchanged, until `rsp_ready` is seen, and then it drops in the next cycle.
- R2: A misaligned read with acquire and reservation both clear is routed like an aligned one. An access is misaligned when the address is not a multiple of its size in bytes (`req_size` 0..3 means 1, 2, 4, 8 bytes).
- R3: A misaligned read with acquire or reservation set returns exception cause 4 and starts no transaction. This check wins over the unsupported-combination check.
- R4: A read with release set and acquire clear, whatever the reservation flag, returns `rsp_unsup`=1, `rsp_exc`=0, cause 0, data 0, and starts no transaction.
- R5: A misaligned write with release or conditional set returns cause 6 and starts no transaction. This check wins over the unsupported-combination check.
- R6: A write with acquire set and release clear, whatever the conditional flag, is answered as unsupported, in the same way as in R4.
- R7: Reads are routed in this order. A data read whose whole byte range lies in the device-readable window goes to the device port. Otherwise, a read whose whole range lies in main memory goes to the memory port. Anything else returns cause 5, and this includes fetches.
- R8: A memory read completed with `mem_nodata` high returns cause 1 for a fetch and cause 5 for a data read, with data 0. A memory read completed with `mem_nodata` low returns `mem_rdata` with no exception. `mem_nodata` has no effect on writes.
- R9: Writes are routed in this order: the whole range in the device-writable window goes to the device port, then the whole range in main memory goes to the memory port, and anything else returns cause 7. `req_fetch` is ignored for writes.
- R10: A routed write carries `txn_order` as set by {acquire, release, conditional}: 000 gives 0 (plain), 010 gives 1 (release), 001 gives 2 (conditional), 011 gives 3 (conditional release), 110 gives 4 (strong release), 111 gives 5 (conditional strong release). A routed read always carries 0.
- R11: During and after reset, `req_ready` is 1 and `mem_valid`, `io_valid` and `rsp_valid` are 0. A reset aborts any pending transaction.
- R12: One cycle after acceptance, the target's valid rises with `txn_addr`, `txn_size`, `txn_wdata` and `txn_write` copied from the request. The valid is held until that target's ack, and the response is valid in the cycle after the ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | log2 of the access size in bytes |
| req_wdata | input | DW | Write data |
| req_acq | input | 1 | Acquire flag |
| req_rel | input | 1 | Release flag |
| req_rsv | input | 1 | Reservation (read) / conditional (write) flag |
| txn_write | output | 1 | Transaction direction |
| txn_addr | output | AW | Transaction address |
| txn_size | output | 2 | Transaction size code |
| txn_wdata | output | DW | Transaction write data |
| txn_order | output | 3 | Ordering tag (R10) |
| mem_valid | output | 1 | Transaction for main memory |
| mem_ack | input | 1 | Main memory completes the transaction |
| mem_rdata | input | DW | Main memory result data |
| mem_nodata | input | 1 | Main memory read produced no data |
| io_valid | output | 1 | Transaction for device space |
| io_ack | input | 1 | Device space completes the transaction |
| io_rdata | input | DW | Device space result data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DW | Result data, 0 on an exception or unsupported request |
| rsp_exc | output | 1 | Response is an exception |
| rsp_cause | output | 4 | Exception cause, 0 when there is none |
| rsp_unsup | output | 1 | Unsupported flag combination |

## Verification
The bench builds the block with a 4 KiB memory window at 0x8000_0000, a 256-byte device-readable window at 0x1000_0000, and a device-writable window covering only the lower 128 bytes of the readable one. The write window is narrower than the read window, so an address exists that can be read from the device port but that faults on a write. The windows are small, so 8-byte accesses can straddle the end of a window. This exercises the whole-range match of R7 and R9, including a plain misaligned read that passes alignment and still faults on its range.

// File: rtl/mar_pkg.sv
package mar_pkg;

  typedef enum logic [2:0] {
    ORD_PLAIN           = 3'd0,
    ORD_REL             = 3'd1,
    ORD_COND            = 3'd2,
    ORD_COND_REL        = 3'd3,
    ORD_STRONG_REL      = 3'd4,
    ORD_COND_STRONG_REL = 3'd5
  } ord_e;

  typedef enum logic [1:0] {
    DST_FAULT = 2'd0,
    DST_UNSUP = 2'd1,
    DST_MEM   = 2'd2,
    DST_IO    = 2'd3
  } dst_e;

  localparam logic [3:0] CAUSE_NONE      = 4'd0;
  localparam logic [3:0] CAUSE_FETCH_ACC = 4'd1;
  localparam logic [3:0] CAUSE_LD_MISAL  = 4'd4;
  localparam logic [3:0] CAUSE_LD_ACC    = 4'd5;
  localparam logic [3:0] CAUSE_ST_MISAL  = 4'd6;
  localparam logic [3:0] CAUSE_ST_ACC    = 4'd7;

  localparam int NREG     = 3;
  localparam int REG_MEM  = 0;
  localparam int REG_IORD = 1;
  localparam int REG_IOWR = 2;

  // low address bits that must be zero for a naturally aligned access
  function automatic logic [2:0] align_mask(input logic [1:0] size);
    return 3'((4'd1 << size) - 4'd1);
  endfunction

endpackage

// File: rtl/mar_flag_check.sv
module mar_flag_check
  import mar_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          acq,
  input  logic          rel,
  input  logic          rsv,
  output logic          misal_fault,
  output logic          unsup,
  output ord_e          order
);

  logic misal;

  always_comb begin
    misal = |(addr[2:0] & align_mask(size));
    if (write) begin
      misal_fault = misal && (rel || rsv);
      unsup       = !misal_fault && acq && !rel;
    end else begin
      misal_fault = misal && (acq || rsv);
      unsup       = !misal_fault && rel && !acq;
    end
    order = ORD_PLAIN;
    if (write) begin
      unique case ({acq, rel, rsv})
        3'b010:  order = ORD_REL;
        3'b001:  order = ORD_COND;
        3'b011:  order = ORD_COND_REL;
        3'b110:  order = ORD_STRONG_REL;
        3'b111:  order = ORD_COND_STRONG_REL;
        default: order = ORD_PLAIN;
      endcase
    end
  end

endmodule

// File: rtl/mar_region_match.sv
module mar_region_match #(
  parameter int            AW    = 32,
  parameter logic [AW-1:0] BASE  = '0,
  parameter logic [AW-1:0] LIMIT = '1
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          hit
);

  localparam int EW = AW + 1;

  logic [EW-1:0] last_byte;

  always_comb begin
    // one extra bit so a range running past the top of the space cannot wrap
    last_byte = {1'b0, addr} + EW'((4'd1 << size) - 4'd1);
    hit       = (addr >= BASE) && (last_byte <= {1'b0, LIMIT});
  end

endmodule

// File: rtl/mar_region_decode.sv
module mar_region_decode
  import mar_pkg::*;
#(
  parameter int            AW          = 32,
  parameter logic [AW-1:0] MEM_BASE    = 32'h8000_0000,
  parameter logic [AW-1:0] MEM_LIMIT   = 32'h8FFF_FFFF,
  parameter logic [AW-1:0] IO_RD_BASE  = 32'h1000_0000,
  parameter logic [AW-1:0] IO_RD_LIMIT = 32'h1000_FFFF,
  parameter logic [AW-1:0] IO_WR_BASE  = 32'h1000_0000,
  parameter logic [AW-1:0] IO_WR_LIMIT = 32'h1000_7FFF
) (
  input  logic          write,
  input  logic          fetch,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          acq,
  input  logic          rel,
  input  logic          rsv,
  output dst_e          dst,
  output logic [3:0]    cause,
  output ord_e          order
);

  localparam logic [AW-1:0] BASES  [NREG] = '{MEM_BASE,  IO_RD_BASE,  IO_WR_BASE};
  localparam logic [AW-1:0] LIMITS [NREG] = '{MEM_LIMIT, IO_RD_LIMIT, IO_WR_LIMIT};

  logic [NREG-1:0] hits;
  logic            misal_fault;
  logic            unsup;

  mar_flag_check #(.AW(AW)) u_flags (
    .write      (write),
    .addr       (addr),
    .size       (size),
    .acq        (acq),
    .rel        (rel),
    .rsv        (rsv),
    .misal_fault(misal_fault),
    .unsup      (unsup),
    .order      (order)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    mar_region_match #(
      .AW   (AW),
      .BASE (BASES[g]),
      .LIMIT(LIMITS[g])
    ) u_match (
      .addr(addr),
      .size(size),
      .hit (hits[g])
    );
  end

  // priority: alignment, flag legality, device window, memory, fault
  always_comb begin
    dst   = DST_FAULT;
    cause = CAUSE_NONE;
    if (misal_fault) begin
      cause = write ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
    end else if (unsup) begin
      dst = DST_UNSUP;
    end else if (write) begin
      if (hits[REG_IOWR])      dst = DST_IO;
      else if (hits[REG_MEM])  dst = DST_MEM;
      else                     cause = CAUSE_ST_ACC;
    end else begin
      if (!fetch && hits[REG_IORD]) dst = DST_IO;
      else if (hits[REG_MEM])       dst = DST_MEM;
      else                          cause = CAUSE_LD_ACC;
    end
  end

endmodule

// File: rtl/mem_access_router.sv
module mem_access_router
  import mar_pkg::*;
#(
  parameter int            AW          = 32,
  parameter int            DW          = 64,
  parameter logic [AW-1:0] MEM_BASE    = 32'h8000_0000,
  parameter logic [AW-1:0] MEM_LIMIT   = 32'h8FFF_FFFF,
  parameter logic [AW-1:0] IO_RD_BASE  = 32'h1000_0000,
  parameter logic [AW-1:0] IO_RD_LIMIT = 32'h1000_FFFF,
  parameter logic [AW-1:0] IO_WR_BASE  = 32'h1000_0000,
  parameter logic [AW-1:0] IO_WR_LIMIT = 32'h1000_7FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_acq,
  input  logic          req_rel,
  input  logic          req_rsv,
  output logic          txn_write,
  output logic [AW-1:0] txn_addr,
  output logic [1:0]    txn_size,
  output logic [DW-1:0] txn_wdata,
  output logic [2:0]    txn_order,
  output logic          mem_valid,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_nodata,
  output logic          io_valid,
  input  logic          io_ack,
  input  logic [DW-1:0] io_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_exc,
  output logic [3:0]    rsp_cause,
  output logic          rsp_unsup
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT_MEM, S_WAIT_IO, S_RESP} state_e;

  state_e     state;
  logic       fetch_q;
  dst_e       dec_dst;
  logic [3:0] dec_cause;
  ord_e       dec_order;
  logic       accept;

  mar_region_decode #(
    .AW         (AW),
    .MEM_BASE   (MEM_BASE),
    .MEM_LIMIT  (MEM_LIMIT),
    .IO_RD_BASE (IO_RD_BASE),
    .IO_RD_LIMIT(IO_RD_LIMIT),
    .IO_WR_BASE (IO_WR_BASE),
    .IO_WR_LIMIT(IO_WR_LIMIT)
  ) u_decode (
    .write(req_write),
    .fetch(req_fetch),
    .addr (req_addr),
    .size (req_size),
    .acq  (req_acq),
    .rel  (req_rel),
    .rsv  (req_rsv),
    .dst  (dec_dst),
    .cause(dec_cause),
    .order(dec_order)
  );

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fetch_q   <= 1'b0;
      txn_write <= 1'b0;
      txn_addr  <= '0;
      txn_size  <= '0;
      txn_wdata <= '0;
      txn_order <= ORD_PLAIN;
      mem_valid <= 1'b0;
      io_valid  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_exc   <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_unsup <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            fetch_q   <= req_fetch && !req_write;
            txn_write <= req_write;
            txn_addr  <= req_addr;
            txn_size  <= req_size;
            txn_wdata <= req_wdata;
            txn_order <= dec_order;
            rsp_data  <= '0;
            rsp_exc   <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_unsup <= 1'b0;
            unique case (dec_dst)
              DST_MEM: begin
                mem_valid <= 1'b1;
                state     <= S_WAIT_MEM;
              end
              DST_IO: begin
                io_valid <= 1'b1;
                state    <= S_WAIT_IO;
              end
              DST_UNSUP: begin
                rsp_valid <= 1'b1;
                rsp_unsup <= 1'b1;
                state     <= S_RESP;
              end
              default: begin
                rsp_valid <= 1'b1;
                rsp_exc   <= 1'b1;
                rsp_cause <= dec_cause;
                state     <= S_RESP;
              end
            endcase
          end
        end
        S_WAIT_MEM: begin
          if (mem_ack) begin
            mem_valid <= 1'b0;
            rsp_valid <= 1'b1;
            state     <= S_RESP;
            if (!txn_write && mem_nodata) begin
              rsp_exc   <= 1'b1;
              rsp_cause <= fetch_q ? CAUSE_FETCH_ACC : CAUSE_LD_ACC;
            end else begin
              rsp_data <= mem_rdata;
            end
          end
        end
        S_WAIT_IO: begin
          if (io_ack) begin
            io_valid  <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= io_rdata;
            state     <= S_RESP;
          end
        end
        default: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mar_checker.sv
module mar_checker #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          req_fetch,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          req_acq,
  input logic          req_rel,
  input logic          req_rsv,
  input logic          mem_valid,
  input logic          mem_ack,
  input logic          io_valid,
  input logic          io_ack,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_exc,
  input logic [3:0]    rsp_cause,
  input logic          rsp_unsup
);

  logic take;
  logic off_grain;

  always_comb begin
    take      = req_valid && req_ready;
    off_grain = |(req_addr[2:0] & 3'((4'd1 << req_size) - 4'd1));
  end

  p_one_target_r7: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && io_valid));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!rsp_valid && !mem_valid && !io_valid));

  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_exc) && $stable(rsp_cause)));

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ack) |=> mem_valid);

  p_io_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (io_valid && !io_ack) |=> io_valid);

  p_unsup_clean_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_unsup) |-> (!rsp_exc && rsp_data == '0));

  p_fetch_no_io_r7: assert property (@(posedge clk) disable iff (rst)
    (take && req_fetch && !req_write) |=> !io_valid);

  p_ld_misal_r3: assert property (@(posedge clk) disable iff (rst)
    (take && !req_write && (req_acq || req_rsv) && off_grain) |=>
      (rsp_valid && rsp_exc && rsp_cause == 4'd4));

  p_st_misal_r5: assert property (@(posedge clk) disable iff (rst)
    (take && req_write && (req_rel || req_rsv) && off_grain) |=>
      (rsp_valid && rsp_exc && rsp_cause == 4'd6));

endmodule

bind mem_access_router mar_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_fetch(req_fetch),
  .req_addr (req_addr),
  .req_size (req_size),
  .req_acq  (req_acq),
  .req_rel  (req_rel),
  .req_rsv  (req_rsv),
  .mem_valid(mem_valid),
  .mem_ack  (mem_ack),
  .io_valid (io_valid),
  .io_ack   (io_ack),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .rsp_exc  (rsp_exc),
  .rsp_cause(rsp_cause),
  .rsp_unsup(rsp_unsup)
);

// File: tb/mem_access_router_tb.sv
module mem_access_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;

  // route codes used in the table
  localparam logic [1:0] RT_FAULT = 2'd0, RT_UNSUP = 2'd1, RT_MEM = 2'd2, RT_IO = 2'd3;

  typedef struct packed {
    logic        wr;
    logic        fe;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        acq;
    logic        rel;
    logic        rsv;
    logic        nod;
    logic [1:0]  route;
    logic [3:0]  cause;
    logic [2:0]  order;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,32'h8000_0010,2'd3,1'b0,1'b0,1'b0,1'b0,RT_MEM,  4'd0,3'd0,4'd7 }, // R7 mem read
    '{1'b0,1'b0,32'h8000_0003,2'd2,1'b0,1'b0,1'b0,1'b0,RT_MEM,  4'd0,3'd0,4'd2 }, // R2 plain misaligned
    '{1'b0,1'b0,32'h8000_0002,2'd2,1'b1,1'b0,1'b0,1'b0,RT_FAULT,4'd4,3'd0,4'd3 }, // R3 acq misaligned
    '{1'b0,1'b0,32'h8000_0001,2'd1,1'b0,1'b0,1'b1,1'b0,RT_FAULT,4'd4,3'd0,4'd3 }, // R3 rsv misaligned
    '{1'b0,1'b0,32'h8000_0008,2'd3,1'b0,1'b1,1'b0,1'b0,RT_UNSUP,4'd0,3'd0,4'd4 }, // R4 rel only
    '{1'b0,1'b0,32'h8000_0004,2'd3,1'b0,1'b1,1'b1,1'b0,RT_FAULT,4'd4,3'd0,4'd3 }, // R3 priority
    '{1'b0,1'b0,32'h8000_0008,2'd3,1'b0,1'b1,1'b1,1'b0,RT_UNSUP,4'd0,3'd0,4'd4 }, // R4 rel+rsv
    '{1'b0,1'b0,32'h1000_0080,2'd2,1'b0,1'b0,1'b0,1'b0,RT_IO,   4'd0,3'd0,4'd7 }, // R7 device read
    '{1'b0,1'b1,32'h1000_0000,2'd2,1'b0,1'b0,1'b0,1'b0,RT_FAULT,4'd5,3'd0,4'd7 }, // R7 fetch skips device
    '{1'b0,1'b1,32'h8000_0040,2'd2,1'b0,1'b0,1'b0,1'b1,RT_MEM,  4'd1,3'd0,4'd8 }, // R8 fetch no data
    '{1'b0,1'b0,32'h8000_0040,2'd2,1'b0,1'b0,1'b0,1'b1,RT_MEM,  4'd5,3'd0,4'd8 }, // R8 load no data
    '{1'b0,1'b0,32'h8000_0FFC,2'd3,1'b0,1'b0,1'b0,1'b0,RT_FAULT,4'd5,3'd0,4'd7 }, // R7 straddles mem end
    '{1'b0,1'b0,32'h1000_00FC,2'd3,1'b0,1'b0,1'b0,1'b0,RT_FAULT,4'd5,3'd0,4'd7 }, // R7 straddles device end
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b0,1'b0,1'b0,1'b1,RT_MEM,  4'd0,3'd0,4'd8 }, // R8 nodata ignored on write
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b0,1'b1,1'b0,1'b0,RT_MEM,  4'd0,3'd1,4'd10}, // R10 release
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b0,1'b0,1'b1,1'b0,RT_MEM,  4'd0,3'd2,4'd10}, // R10 conditional
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b0,1'b1,1'b1,1'b0,RT_MEM,  4'd0,3'd3,4'd10}, // R10 cond release
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b1,1'b1,1'b0,1'b0,RT_MEM,  4'd0,3'd4,4'd10}, // R10 strong release
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b1,1'b1,1'b1,1'b0,RT_MEM,  4'd0,3'd5,4'd10}, // R10 cond strong
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b1,1'b0,1'b0,1'b0,RT_UNSUP,4'd0,3'd0,4'd6 }, // R6 acq only
    '{1'b1,1'b0,32'h8000_0020,2'd3,1'b1,1'b0,1'b1,1'b0,RT_UNSUP,4'd0,3'd0,4'd6 }, // R6 acq+cond
    '{1'b1,1'b0,32'h8000_0002,2'd2,1'b0,1'b1,1'b0,1'b0,RT_FAULT,4'd6,3'd0,4'd5 }, // R5 rel misaligned
    '{1'b1,1'b0,32'h8000_0001,2'd1,1'b1,1'b0,1'b1,1'b0,RT_FAULT,4'd6,3'd0,4'd5 }, // R5 priority
    '{1'b1,1'b0,32'h8000_0001,2'd2,1'b0,1'b0,1'b0,1'b0,RT_MEM,  4'd0,3'd0,4'd9 }, // R9 plain misaligned write
    '{1'b1,1'b0,32'h1000_0010,2'd2,1'b0,1'b0,1'b0,1'b0,RT_IO,   4'd0,3'd0,4'd9 }, // R9 device write
    '{1'b1,1'b0,32'h1000_0080,2'd2,1'b0,1'b0,1'b0,1'b0,RT_FAULT,4'd7,3'd0,4'd9 }, // R9 read-only window
    '{1'b1,1'b0,32'h2000_0000,2'd2,1'b0,1'b0,1'b0,1'b0,RT_FAULT,4'd7,3'd0,4'd9 }, // R9 unmapped
    '{1'b0,1'b0,32'h8000_0030,2'd3,1'b1,1'b1,1'b0,1'b0,RT_MEM,  4'd0,3'd0,4'd10}, // R10 read tag plain
    '{1'b1,1'b1,32'h1000_0010,2'd2,1'b0,1'b1,1'b0,1'b0,RT_IO,   4'd0,3'd1,4'd9 }, // R9 fetch bit ignored
    '{1'b0,1'b0,32'h8000_0FF8,2'd3,1'b0,1'b0,1'b0,1'b0,RT_MEM,  4'd0,3'd0,4'd7 }  // R7 last full word
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic          req_acq = 1'b0, req_rel = 1'b0, req_rsv = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          txn_write;
  logic [AW-1:0] txn_addr;
  logic [1:0]    txn_size;
  logic [DW-1:0] txn_wdata;
  logic [2:0]    txn_order;
  logic          mem_valid, io_valid;
  logic          mem_ack = 1'b0, mem_nodata = 1'b0, io_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0, io_rdata = '0;
  logic          rsp_valid, rsp_exc, rsp_unsup;
  logic          rsp_ready = 1'b0;
  logic [DW-1:0] rsp_data;
  logic [3:0]    rsp_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_access_router #(
    .AW(AW), .DW(DW),
    .MEM_BASE(32'h8000_0000),   .MEM_LIMIT(32'h8000_0FFF),
    .IO_RD_BASE(32'h1000_0000), .IO_RD_LIMIT(32'h1000_00FF),
    .IO_WR_BASE(32'h1000_0000), .IO_WR_LIMIT(32'h1000_007F)
  ) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    string t;
    logic [DW-1:0] rd, exp_data;
    bit exc;
    v  = VECS[i];
    t  = $sformatf("R%0d vec %0d", v.rq, i);
    rd = {32'hD00D_0000, 32'(i)};
    exc = (v.cause != 4'd0);
    @(negedge clk);
    chk(req_ready == 1'b1, {t, " R1 ready idle"}, 64'(req_ready), 64'd1);
    req_write = v.wr; req_fetch = v.fe; req_addr = v.addr; req_size = v.size;
    req_acq = v.acq; req_rel = v.rel; req_rsv = v.rsv;
    req_wdata = {32'hC0DE_0000, 32'(i)};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.route == RT_MEM || v.route == RT_IO) begin
      chk(mem_valid == (v.route == RT_MEM), {t, " mem_valid"}, 64'(mem_valid), 64'(v.route == RT_MEM));
      chk(io_valid == (v.route == RT_IO), {t, " io_valid"}, 64'(io_valid), 64'(v.route == RT_IO));
      chk(txn_order == v.order, {t, " R10 order"}, 64'(txn_order), 64'(v.order));
      chk(txn_addr == v.addr && txn_size == v.size && txn_write == v.wr &&
          txn_wdata == {32'hC0DE_0000, 32'(i)}, {t, " R12 fields"}, 64'(txn_addr), 64'(v.addr));
      @(negedge clk);
      chk((mem_valid || io_valid) && !rsp_valid, {t, " R12 held"}, 64'(mem_valid | io_valid), 64'd1);
      mem_rdata = rd; io_rdata = rd; mem_nodata = v.nod;
      if (v.route == RT_MEM) mem_ack = 1'b1; else io_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0; io_ack = 1'b0; mem_nodata = 1'b0;
      chk(!mem_valid && !io_valid, {t, " R12 drop"}, 64'(mem_valid | io_valid), 64'd0);
      exp_data = exc ? '0 : rd;
    end else begin
      chk(!mem_valid && !io_valid, {t, " no txn"}, 64'(mem_valid | io_valid), 64'd0);
      exp_data = '0;
    end
    chk(rsp_valid == 1'b1, {t, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_exc == exc, {t, " rsp_exc"}, 64'(rsp_exc), 64'(exc));
    chk(rsp_cause == v.cause, {t, " cause"}, 64'(rsp_cause), 64'(v.cause));
    chk(rsp_unsup == (v.route == RT_UNSUP), {t, " unsup"}, 64'(rsp_unsup), 64'(v.route == RT_UNSUP));
    chk(rsp_data == exp_data, {t, " data"}, rsp_data, exp_data);
    chk(req_ready == 1'b0, {t, " R1 busy"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(rsp_valid && rsp_data == exp_data && rsp_cause == v.cause, {t, " R1 hold"},
        64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, {t, " R1 release"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1 && !mem_valid && !io_valid && !rsp_valid, "R11 reset state",
        {60'd0, req_ready, mem_valid, io_valid, rsp_valid}, 64'h8);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: a request held high while a response waits is not taken
    @(negedge clk);
    req_write = 1'b1; req_fetch = 1'b0; req_addr = 32'h2000_0000; req_size = 2'd0;
    req_acq = 1'b0; req_rel = 1'b0; req_rsv = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h8000_0000;
    repeat (2) @(negedge clk);
    chk(!mem_valid && rsp_valid && rsp_cause == 4'd7, "R1 second request blocked",
        64'(rsp_cause), 64'd7);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // R11: reset aborts a pending memory transaction
    @(negedge clk);
    req_write = 1'b0; req_addr = 32'h8000_0100; req_size = 2'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_valid == 1'b1, "R11 pre-reset mem pending", 64'(mem_valid), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(!mem_valid && !rsp_valid && req_ready, "R11 reset aborts",
        {61'd0, mem_valid, rsp_valid, req_ready}, 64'd1);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule